// File: doc/BRIEF.md
# Programmable 3x3 Color Matrix Converter

This block is a streaming pixel datapath that multiplies every incoming three-component pixel by a programmable 3x3 matrix of signed fixed-point gains. It adds a signed offset to each output channel and then limits each result to a programmable window. Typical uses are converting between RGB and luma/chroma representations, or passing pixels through unchanged. Pixels arrive one per beat on a valid/ready handshake and leave on the same kind of handshake. The pipeline accepts one pixel every clock when nothing stalls it.

The component depth is fixed at elaboration by `DEPTH` (8, 10, 12 or 16). Coefficients, offsets and the lower and upper limits come in on plain configuration buses. The block copies them into its working set only on an accepted beat that carries the start-of-frame flag, so a frame never mixes two matrices. Chroma resampling is outside this block: it handles pixels as three independent samples.

Top module: `color_matrix_conv`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. The working configuration is the identity matrix (4096 on the diagonal, 0 elsewhere), all offsets are 0, the lower limit is 0 and the upper limit is 2^DEPTH-1, so pixels pass through unchanged.
- R2: Output channel i equals round((K[i][0]*c0 + K[i][1]*c1 + K[i][2]*c2) / 4096) + offset i, before limiting. Coefficient K[i][j] is a signed two's-complement `COEF_W`-bit value at bits [(3i+j)*COEF_W +: COEF_W] of `cfg_coef` (row-major), where 4096 means a gain of 1.0.
- R3: Rounding adds 2048 to the full-precision sum and then shifts it arithmetically right by 12. No intermediate result wraps, including with extreme coefficients and full-scale pixels.
- R4: Offset i is a signed two's-complement `OFS_W`-bit value at bits [i*OFS_W +: OFS_W] of `cfg_ofs`. It is given in output sample units and is added after rounding, so negative offsets are supported.
- R5: Each offset result r is first raised to at least `cfg_min` and then lowered to at most `cfg_max`. When `cfg_min` exceeds `cfg_max`, every output equals `cfg_max`.
- R6: The configuration buses are copied only on a beat that is accepted with `s_sof` = 1. That beat and all later beats use the new values. Changing the buses at any other time has no effect on any output.
- R7: A pixel accepted at clock edge N appears on `m_valid`/`m_pix` after edge N+2 when the output is not stalled, which is a latency of three register stages.
- R8: `s_ready` is 1 when `m_ready` is 1 or no output is pending. While `m_valid` is 1 and `m_ready` is 0, the output holds still. No pixel is lost, duplicated or reordered.
- R9: Component j of a pixel sits at bits [j*DEPTH +: DEPTH] of `s_pix` and `m_pix`. The start-of-frame flag travels with its pixel to `m_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_coef | input | 9*COEF_W | Nine signed Q12 coefficients, row-major |
| cfg_ofs | input | 3*OFS_W | Three signed per-channel offsets |
| cfg_min | input | DEPTH | Lower limit applied to every channel |
| cfg_max | input | DEPTH | Upper limit applied to every channel |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_sof | input | 1 | Input pixel is the first of a frame |
| s_pix | input | 3*DEPTH | Input pixel, three components |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream can take the output pixel |
| m_sof | output | 1 | Output pixel is the first of a frame |
| m_pix | output | 3*DEPTH | Converted pixel |

## Verification
The hardest case is a frame boundary that arrives while pixels of the previous frame are still inside the pipeline and the output is stalled. Here the new matrix must apply to the start-of-frame pixel, and the older pixels must keep the old one. The stimulus sends frames back to back under a randomly toggled `m_ready`, changes the configuration buses in the middle of frames without a start flag, and feeds both the extreme coefficients and the rounding midpoints. A behavioural queue model updates its own matrix only on accepted start beats, and it checks every output transfer and every held output cycle.

// File: rtl/cmc_pkg.sv
`timescale 1ns/1ps
package cmc_pkg;
    // fractional bits of the coefficient format: 1 << FRAC_BITS is unity gain
    localparam int FRAC_BITS = 12;
    // components per pixel
    localparam int NCH = 3;
endpackage

// File: rtl/cmc_cfg_bank.sv
`timescale 1ns/1ps
module cmc_cfg_bank
    import cmc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int COEF_W = 18,
    parameter int OFS_W  = DEPTH + 2
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NCH*NCH*COEF_W-1:0]   coef_in,
    input  logic [NCH*OFS_W-1:0]        ofs_in,
    input  logic [DEPTH-1:0]            min_in,
    input  logic [DEPTH-1:0]            max_in,
    output logic [NCH*NCH*COEF_W-1:0]   coef_use,
    output logic [NCH*OFS_W-1:0]        ofs_use,
    output logic [DEPTH-1:0]            min_use,
    output logic [DEPTH-1:0]            max_use,
    output logic [NCH*NCH*COEF_W-1:0]   coef_act
);
    localparam int NK   = NCH * NCH;
    localparam int CW_T = NK * COEF_W;

    function automatic logic [CW_T-1:0] ident_matrix();
        logic [CW_T-1:0] v;
        v = '0;
        for (int k = 0; k < NK; k += NCH + 1)
            v[k*COEF_W +: COEF_W] = COEF_W'(1 << FRAC_BITS);
        return v;
    endfunction

    localparam logic [CW_T-1:0] IDENT = ident_matrix();

    typedef struct packed {
        logic [CW_T-1:0]        coef;
        logic [NCH*OFS_W-1:0]   ofs;
        logic [DEPTH-1:0]       lo;
        logic [DEPTH-1:0]       hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.coef = coef_in;
            cfg_d.ofs  = ofs_in;
            cfg_d.lo   = min_in;
            cfg_d.hi   = max_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.coef <= IDENT;
            cfg_q.ofs  <= '0;
            cfg_q.lo   <= '0;
            cfg_q.hi   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // the start beat itself already uses the incoming set
    assign coef_use = load ? coef_in : cfg_q.coef;
    assign ofs_use  = load ? ofs_in  : cfg_q.ofs;
    assign min_use  = load ? min_in  : cfg_q.lo;
    assign max_use  = load ? max_in  : cfg_q.hi;
    assign coef_act = cfg_q.coef;
endmodule

// File: rtl/cmc_row_mul.sv
`timescale 1ns/1ps
module cmc_row_mul
    import cmc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int COEF_W = 18,
    parameter int PROD_W = DEPTH + 1 + COEF_W
)(
    input  logic [NCH*DEPTH-1:0]  pix,
    input  logic [NCH*COEF_W-1:0] coef,
    output logic [NCH*PROD_W-1:0] prod
);
    for (genvar j = 0; j < NCH; j++) begin : g_tap
        logic signed [PROD_W-1:0] a_s;
        logic signed [PROD_W-1:0] b_s;
        // sample is unsigned: zero-extend; gain is signed: sign-extend
        assign a_s = PROD_W'(pix[j*DEPTH +: DEPTH]);
        assign b_s = PROD_W'($signed(coef[j*COEF_W +: COEF_W]));
        assign prod[j*PROD_W +: PROD_W] = a_s * b_s;
    end
endmodule

// File: rtl/cmc_row_fin.sv
`timescale 1ns/1ps
module cmc_row_fin
    import cmc_pkg::*;
#(
    parameter int PROD_W = 27,
    parameter int OFS_W  = 10,
    parameter int RES_W  = PROD_W + 3
)(
    input  logic [NCH*PROD_W-1:0] prod,
    input  logic [OFS_W-1:0]      ofs,
    output logic [RES_W-1:0]      res
);
    localparam int SUM_W = RES_W - 1;

    logic signed [SUM_W-1:0] acc_s;
    logic signed [SUM_W-1:0] rnd_s;
    logic signed [SUM_W-1:0] shf_s;

    always_comb begin
        acc_s = '0;
        for (int j = 0; j < NCH; j++)
            acc_s = acc_s + SUM_W'($signed(prod[j*PROD_W +: PROD_W]));
        rnd_s = acc_s + SUM_W'(1 << (FRAC_BITS - 1));
        shf_s = rnd_s >>> FRAC_BITS;
        res   = RES_W'(shf_s) + RES_W'($signed(ofs));
    end
endmodule

// File: rtl/color_matrix_conv.sv
`timescale 1ns/1ps
module color_matrix_conv
    import cmc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int COEF_W = 18,
    parameter int OFS_W  = DEPTH + 2
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [9*COEF_W-1:0]       cfg_coef,
    input  logic [3*OFS_W-1:0]        cfg_ofs,
    input  logic [DEPTH-1:0]          cfg_min,
    input  logic [DEPTH-1:0]          cfg_max,
    input  logic                      s_valid,
    output logic                      s_ready,
    input  logic                      s_sof,
    input  logic [3*DEPTH-1:0]        s_pix,
    output logic                      m_valid,
    input  logic                      m_ready,
    output logic                      m_sof,
    output logic [3*DEPTH-1:0]        m_pix
);
    localparam int NK     = NCH * NCH;
    localparam int PROD_W = DEPTH + 1 + COEF_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam int RES_W  = SUM_W + 1;

    typedef struct packed {
        logic                     s1_v;
        logic                     s1_sof;
        logic [NK*PROD_W-1:0]     s1_prod;
        logic [NCH*OFS_W-1:0]     s1_ofs;
        logic [DEPTH-1:0]         s1_min;
        logic [DEPTH-1:0]         s1_max;
        logic                     s2_v;
        logic                     s2_sof;
        logic [NCH*RES_W-1:0]     s2_res;
        logic [DEPTH-1:0]         s2_min;
        logic [DEPTH-1:0]         s2_max;
        logic                     s3_v;
        logic                     s3_sof;
        logic [NCH*DEPTH-1:0]     s3_pix;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                     adv;
    logic                     take;
    logic                     load;
    logic [NK*COEF_W-1:0]     coef_use;
    logic [NK*COEF_W-1:0]     coef_act;
    logic [NCH*OFS_W-1:0]     ofs_use;
    logic [DEPTH-1:0]         min_use;
    logic [DEPTH-1:0]         max_use;
    logic [NK*PROD_W-1:0]     prod_all;
    logic [NCH*RES_W-1:0]     res_all;

    // whole pipeline moves together; it may move whenever the last stage drains
    assign adv  = m_ready || !st_q.s3_v;
    assign take = s_valid && adv;
    assign load = take && s_sof;

    cmc_cfg_bank #(
        .DEPTH  (DEPTH),
        .COEF_W (COEF_W),
        .OFS_W  (OFS_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .coef_in  (cfg_coef),
        .ofs_in   (cfg_ofs),
        .min_in   (cfg_min),
        .max_in   (cfg_max),
        .coef_use (coef_use),
        .ofs_use  (ofs_use),
        .min_use  (min_use),
        .max_use  (max_use),
        .coef_act (coef_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_row
        cmc_row_mul #(
            .DEPTH  (DEPTH),
            .COEF_W (COEF_W),
            .PROD_W (PROD_W)
        ) u_mul (
            .pix  (s_pix),
            .coef (coef_use[i*NCH*COEF_W +: NCH*COEF_W]),
            .prod (prod_all[i*NCH*PROD_W +: NCH*PROD_W])
        );

        cmc_row_fin #(
            .PROD_W (PROD_W),
            .OFS_W  (OFS_W),
            .RES_W  (RES_W)
        ) u_fin (
            .prod (st_q.s1_prod[i*NCH*PROD_W +: NCH*PROD_W]),
            .ofs  (st_q.s1_ofs[i*OFS_W +: OFS_W]),
            .res  (res_all[i*RES_W +: RES_W])
        );
    end

    always_comb begin
        logic signed [RES_W-1:0] r_s;
        logic signed [RES_W-1:0] lo_s;
        logic signed [RES_W-1:0] hi_s;
        st_d = st_q;
        r_s  = '0;
        lo_s = $signed(RES_W'(st_q.s2_min));
        hi_s = $signed(RES_W'(st_q.s2_max));
        if (adv) begin
            // stage 1: products and the configuration this pixel travels with
            st_d.s1_v    = s_valid;
            st_d.s1_sof  = s_valid && s_sof;
            st_d.s1_prod = prod_all;
            st_d.s1_ofs  = ofs_use;
            st_d.s1_min  = min_use;
            st_d.s1_max  = max_use;
            // stage 2: rounded row sums plus offset
            st_d.s2_v    = st_q.s1_v;
            st_d.s2_sof  = st_q.s1_sof;
            st_d.s2_res  = res_all;
            st_d.s2_min  = st_q.s1_min;
            st_d.s2_max  = st_q.s1_max;
            // stage 3: lower clamp first, upper clip last
            st_d.s3_v    = st_q.s2_v;
            st_d.s3_sof  = st_q.s2_sof;
            for (int c = 0; c < NCH; c++) begin
                r_s = $signed(st_q.s2_res[c*RES_W +: RES_W]);
                if (r_s < lo_s) r_s = lo_s;
                if (r_s > hi_s) r_s = hi_s;
                st_d.s3_pix[c*DEPTH +: DEPTH] = r_s[DEPTH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_ready = adv;
    assign m_valid = st_q.s3_v;
    assign m_sof   = st_q.s3_sof;
    assign m_pix   = st_q.s3_pix;

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_pix) && $stable(m_sof));

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |=> st_q.s1_v);

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready && s_sof) |=> $stable(coef_act));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(adv) && m_valid |-> m_pix[c*DEPTH +: DEPTH] <= $past(st_q.s2_max));
    end
endmodule

// File: tb/color_matrix_conv_tb.sv
`timescale 1ns/1ps
module color_matrix_conv_tb;
    localparam int D  = 10;
    localparam int CW = 18;
    localparam int OW = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [9*CW-1:0]  cfg_coef;
    logic [3*OW-1:0]  cfg_ofs;
    logic [D-1:0]     cfg_min;
    logic [D-1:0]     cfg_max;
    logic             s_valid;
    logic             s_ready;
    logic             s_sof;
    logic [3*D-1:0]   s_pix;
    logic             m_valid;
    logic             m_ready;
    logic             m_sof;
    logic [3*D-1:0]   m_pix;

    always #2.5 clk = ~clk;

    color_matrix_conv #(.DEPTH(D), .COEF_W(CW), .OFS_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_coef(cfg_coef), .cfg_ofs(cfg_ofs),
        .cfg_min(cfg_min), .cfg_max(cfg_max), .s_valid(s_valid), .s_ready(s_ready),
        .s_sof(s_sof), .s_pix(s_pix), .m_valid(m_valid), .m_ready(m_ready),
        .m_sof(m_sof), .m_pix(m_pix)
    );

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc    = 0;
    string       tag    = "R1";
    logic        stall_mode = 1'b0;
    logic        prev_stall = 1'b0;
    logic [3*D:0] prev_out  = '0;
    logic [3*D:0] expq[$];

    int m_k[9];
    int m_o[3];
    int m_lo;
    int m_hi;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [3*D-1:0] model(input logic [3*D-1:0] p);
        logic [3*D-1:0] r;
        longint s;
        r = '0;
        for (int i = 0; i < 3; i++) begin
            s = 0;
            for (int j = 0; j < 3; j++)
                s += longint'(m_k[i*3+j]) * longint'(p[j*D +: D]);
            s = (s + 2048) >>> 12;
            s = s + m_o[i];
            if (s < m_lo) s = m_lo;
            if (s > m_hi) s = m_hi;
            r[i*D +: D] = s[D-1:0];
        end
        return r;
    endfunction

    function automatic logic [3*D-1:0] rnd_pix();
        return {D'($urandom), D'($urandom), D'($urandom)};
    endfunction

    task automatic capture_cfg();
        for (int k = 0; k < 9; k++) m_k[k] = $signed(cfg_coef[k*CW +: CW]);
        for (int i = 0; i < 3; i++) m_o[i] = $signed(cfg_ofs[i*OW +: OW]);
        m_lo = int'(cfg_min);
        m_hi = int'(cfg_max);
    endtask

    task automatic set_cfg(input int k[9], input int o[3], input int lo, input int hi);
        for (int n = 0; n < 9; n++) cfg_coef[n*CW +: CW] = CW'(k[n]);
        for (int n = 0; n < 3; n++) cfg_ofs[n*OW +: OW] = OW'(o[n]);
        cfg_min = D'(lo);
        cfg_max = D'(hi);
    endtask

    task automatic check(input logic ok, input string what, input logic [3*D:0] act, input logic [3*D:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic sf, input logic [3*D-1:0] px,
                        input logic rdy, output logic took);
        logic [3*D:0] e;
        @(negedge clk);
        s_valid = v;
        s_sof   = sf;
        s_pix   = px;
        m_ready = rdy;
        #1;
        if (prev_stall) begin
            checks++;
            if (!m_valid || {m_sof, m_pix} !== prev_out) begin
                errors++;
                $display("FAIL R8 stalled output moved actual %h expected %h",
                         {m_valid, m_sof, m_pix}, {1'b1, prev_out});
            end
        end
        prev_stall = m_valid && !m_ready;
        prev_out   = {m_sof, m_pix};
        if (m_valid && m_ready) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 extra output actual %h expected none", {m_sof, m_pix});
            end else begin
                e = expq.pop_front();
                check({m_sof, m_pix} === e, "pixel", {m_sof, m_pix}, e);
            end
        end
        took = v && s_ready;
        if (took) begin
            if (sf) capture_cfg();
            expq.push_back({sf, model(px)});
        end
    endtask

    task automatic send(input logic sf, input logic [3*D-1:0] px);
        logic took;
        took = 1'b0;
        while (!took)
            step(1'b1, sf, px, !stall_mode || ($urandom_range(0, 3) != 0), took);
    endtask

    task automatic idle(input int n);
        logic t;
        for (int i = 0; i < n; i++)
            step(1'b0, 1'b0, '0, !stall_mode || ($urandom_range(0, 1) != 0), t);
    endtask

    task automatic drain();
        logic t;
        for (int i = 0; i < 40 && expq.size() != 0; i++)
            step(1'b0, 1'b0, '0, 1'b1, t);
        check(expq.size() == 0, "pixels missing after drain", (3*D+1)'(expq.size()), '0);
    endtask

    task automatic frame(input int n, input logic gaps);
        for (int i = 0; i < n; i++) begin
            send(i == 0, rnd_pix());
            if (gaps && $urandom_range(0, 4) == 0) idle(1);
        end
    endtask

    initial begin
        logic t;
        int   lat;
        rst_n = 1'b0; s_valid = 1'b0; s_sof = 1'b0; s_pix = '0; m_ready = 1'b0;
        set_cfg('{1, 2, 3, 4, 5, 6, 7, 8, 9}, '{11, 22, 33}, 5, 6);
        // bench model starts from the reset configuration R1
        m_k = '{4096, 0, 0, 0, 4096, 0, 0, 0, 4096};
        m_o = '{0, 0, 0};
        m_lo = 0;
        m_hi = (1 << D) - 1;
        repeat (3) @(negedge clk);
        tag = "R1";
        check(m_valid == 1'b0, "valid in reset", {30'b0, m_valid}, '0);
        rst_n = 1'b1;
        #1;
        check(s_ready == 1'b1, "ready after reset", {30'b0, s_ready}, 31'd1);

        // R1: identity pass-through with garbage on the buses and no start flag
        for (int i = 0; i < 16; i++) send(1'b0, rnd_pix());
        // R9: component positions are kept apart
        tag = "R9";
        send(1'b0, {10'h3FF, 10'h200, 10'h001});
        send(1'b0, {10'h000, 10'h155, 10'h2AA});
        drain();

        // R7: latency of three stages
        tag = "R7";
        step(1'b1, 1'b0, {10'd7, 10'd8, 10'd9}, 1'b1, t);
        lat = 0;
        for (int i = 0; i < 8 && !m_valid; i++) begin
            step(1'b0, 1'b0, '0, 1'b1, t);
            lat++;
        end
        check(lat == 3, "latency", (3*D+1)'(lat), (3*D+1)'(3));
        drain();

        // R6: new set only at a start beat; mid-frame bus changes ignored
        tag = "R6";
        stall_mode = 1'b1;
        set_cfg('{8192, 0, 0, 0, 2048, 0, 0, 0, 4096}, '{3, -3, 0}, 0, 1023);
        for (int i = 0; i < 8; i++) send(1'b0, rnd_pix());
        send(1'b1, rnd_pix());
        for (int i = 0; i < 5; i++) send(1'b0, rnd_pix());
        set_cfg('{0, 4096, 0, 4096, 0, 0, 0, 0, 4096}, '{100, 100, 100}, 200, 300);
        for (int i = 0; i < 8; i++) send(1'b0, rnd_pix());

        // R2: matrix with negative rows, frames back to back under stalls
        tag = "R2";
        set_cfg('{748, 2516, 254, -412, -1387, 1799, 1799, -1634, -165}, '{64, 512, 512}, 0, 1023);
        frame(30, 1'b1);
        frame(30, 1'b0);

        // R4: negative offsets drive results below zero
        tag = "R4";
        set_cfg('{4770, 0, 7343, 4770, -873, -2183, 4770, 8652, 0}, '{-992, 308, -1156}, 0, 1023);
        send(1'b1, {10'd0, 10'd0, 10'd0});
        send(1'b0, {10'h3FF, 10'h3FF, 10'h3FF});
        send(1'b0, {10'h3FF, 10'd0, 10'd64});
        frame(20, 1'b1);

        // R5: programmable window, then an inverted window
        tag = "R5";
        set_cfg('{4096, 0, 0, 0, 4096, 0, 0, 0, 4096}, '{0, 0, 0}, 64, 940);
        send(1'b1, {10'd10, 10'd500, 10'd1000});
        frame(16, 1'b0);
        set_cfg('{4096, 0, 0, 0, 4096, 0, 0, 0, 4096}, '{0, 0, 0}, 700, 300);
        send(1'b1, {10'd10, 10'd500, 10'd1000});
        for (int i = 0; i < 6; i++) send(1'b0, rnd_pix());

        // R3: extreme gains and rounding midpoints
        tag = "R3";
        set_cfg('{131071, 131071, 131071, -131072, -131072, -131072, 131071, -131072, 131071},
                '{2047, -2048, 0}, 0, 1023);
        send(1'b1, {10'h3FF, 10'h3FF, 10'h3FF});
        send(1'b0, {10'h3FF, 10'h000, 10'h3FF});
        send(1'b0, rnd_pix());
        set_cfg('{2048, 0, 0, -2048, 0, 0, 2048, -2048, 2048}, '{0, 5, 0}, 0, 1023);
        send(1'b1, {10'd0, 10'd0, 10'd1});
        send(1'b0, {10'd0, 10'd0, 10'd3});
        send(1'b0, {10'd1, 10'd1, 10'd2});
        for (int i = 0; i < 10; i++) send(1'b0, rnd_pix());

        // R8: long output stall then full drain
        tag = "R8";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, rnd_pix(), 1'b0, t);
        if (t) expq.pop_back();
        s_valid = 1'b0;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, 1'b0, t);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule